// File: doc/BRIEF.md
# Transmit Word Boundary Bit Slipper

This block sits in a transmit path between the parallel fabric interface and the serializer gearbox. It takes one parallel word per clock and a slip amount. It outputs a registered word whose boundary has moved by that many bit positions. The bits that enter the low end of the output come from the top of the word accepted before. They do not wrap around within the current word.

One copy serves one channel, and each channel has its own slip input. Word history is held in a small controller with two named states. `HS_EMPTY` is the state after reset, when the history register is still cleared. `HS_STREAM` is entered on the first accepted word. The transition `T_FIRST` (`HS_EMPTY` to `HS_STREAM`) fires on the first cycle with input valid high. `T_HOLD` keeps the current state on every other cycle. Reset always returns the controller to `HS_EMPTY`.

The usable slip range is `SLIP_MAX = min(DATA_W-1, 2^SLIP_W-1)`. With the defaults (64-bit words, 5-bit control) this is 0 to 31.

Top module: `tx_word_slipper`

## Requirements
- R1: `dout_vld` equals `din_vld` delayed by exactly one clock, for every slip value.
- R2: With an effective slip of 0, `dout` on the cycle after a valid input equals that input word unchanged.
- R3: With an effective slip s from 1 to SLIP_MAX, the output is built from two words. Output bits [s-1:0] are bits [DATA_W-1:DATA_W-s] of the previous accepted word. Output bits [DATA_W-1:s] are bits [DATA_W-1-s:0] of the current word.
- R4: The history word changes only on cycles with `din_vld` high. After a gap of invalid cycles, the next output splices in the last accepted word.
- R5: After reset, `dout_vld` is 0 and `dout` is 0. The history is zero, so the first word after reset fills its slipped-in low bits with zeros.
- R6: A `slip` value above SLIP_MAX is treated as SLIP_MAX.
- R7: `slip` is sampled on every valid cycle. A new value applies to the very next output word, with no flush or idle cycle.
- R8: While `dout_vld` is low, `dout` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din_vld | input | 1 | Input word valid |
| din | input | DATA_W | Input parallel word |
| slip | input | SLIP_W | Requested boundary shift in bits |
| dout_vld | output | 1 | Output word valid |
| dout | output | DATA_W | Slipped output word |

## Verification
The assertions assume that `din_vld`, `din` and `slip` are driven to known values at every clock edge outside reset. They also assume `slip` is only meaningful when `din_vld` is high. The bench changes inputs only on falling edges and always drives all three. It mixes back-to-back valid words with idle gaps and slip changes. A second copy with a 16-bit word, where a 5-bit slip can exceed the width, covers the clamp.

// File: rtl/bslip_pkg.sv
package bslip_pkg;

    typedef enum logic [0:0] {
        HS_EMPTY  = 1'b0,
        HS_STREAM = 1'b1
    } hist_state_e;

    function automatic int slip_limit(input int data_w, input int slip_w);
        int ctl_max;
        ctl_max = (1 << slip_w) - 1;
        return ((data_w - 1) < ctl_max) ? (data_w - 1) : ctl_max;
    endfunction

endpackage

// File: rtl/bslip_clamp.sv
module bslip_clamp #(
    parameter int SLIP_W   = 5,
    parameter int SLIP_MAX = 31,
    parameter int IDX_W    = 5
) (
    input  logic [SLIP_W-1:0] slip_req,
    output logic [IDX_W-1:0]  slip_eff
);

    logic [31:0] req_wide;

    assign req_wide = 32'(slip_req);

    always_comb begin
        if (req_wide > 32'(SLIP_MAX)) begin
            slip_eff = IDX_W'(SLIP_MAX);
        end else begin
            slip_eff = IDX_W'(slip_req);
        end
    end

    // R6: the effective slip never leaves the legal range
    always_comb begin
        a_r6_eff_in_range: assert (32'(slip_eff) <= 32'(SLIP_MAX) || $isunknown(slip_req));
    end

endmodule

// File: rtl/bslip_hist.sv
module bslip_hist
    import bslip_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] prev_word
);

    hist_state_e state_q;
    hist_state_e state_d;
    logic [DATA_W-1:0] prev_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_EMPTY:  if (take) state_d = HS_STREAM;  // T_FIRST
            HS_STREAM: state_d = HS_STREAM;            // T_HOLD
            default:   state_d = HS_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // history output register
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else if (take) begin
            prev_q <= word_in;
        end
    end

    assign prev_word = prev_q;

    // R4: history captures an accepted word
    a_r4_hist_load: assert property (@(posedge clk) disable iff (rst)
        take |=> prev_q == $past(word_in));

    // R4: history ignores idle cycles
    a_r4_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(prev_q));

    // R5: no word accepted yet, history still cleared
    a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_EMPTY) |-> (prev_q == '0));

endmodule

// File: rtl/bslip_splice.sv
module bslip_splice #(
    parameter int DATA_W   = 64,
    parameter int SLIP_MAX = 31,
    parameter int IDX_W    = 5
) (
    input  logic [DATA_W-1:0] prev_word,
    input  logic [DATA_W-1:0] cur_word,
    input  logic [IDX_W-1:0]  slip_eff,
    output logic [DATA_W-1:0] spliced
);

    logic [DATA_W-1:0] cand [SLIP_MAX+1];

    generate
        for (genvar k = 0; k <= SLIP_MAX; k++) begin : gen_cand
            if (k == 0) begin : g_pass
                assign cand[k] = cur_word;
            end else begin : g_join
                assign cand[k] = {cur_word[DATA_W-1-k:0], prev_word[DATA_W-1:DATA_W-k]};
            end
        end
    endgenerate

    always_comb begin
        spliced = cur_word;
        for (int k = 0; k <= SLIP_MAX; k++) begin
            if (slip_eff == IDX_W'(k)) spliced = cand[k];
        end
    end

endmodule

// File: rtl/tx_word_slipper.sv
module tx_word_slipper
    import bslip_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SLIP_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din_vld,
    input  logic [DATA_W-1:0] din,
    input  logic [SLIP_W-1:0] slip,
    output logic              dout_vld,
    output logic [DATA_W-1:0] dout
);

    localparam int SLIP_MAX = slip_limit(DATA_W, SLIP_W);
    localparam int IDX_W    = (SLIP_MAX < 1) ? 1 : $clog2(SLIP_MAX + 1);

    logic [IDX_W-1:0]  slip_eff;
    logic [DATA_W-1:0] prev_word;
    logic [DATA_W-1:0] spliced;
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    bslip_clamp #(
        .SLIP_W   (SLIP_W),
        .SLIP_MAX (SLIP_MAX),
        .IDX_W    (IDX_W)
    ) u_clamp (
        .slip_req (slip),
        .slip_eff (slip_eff)
    );

    bslip_hist #(
        .DATA_W (DATA_W)
    ) u_hist (
        .clk       (clk),
        .rst       (rst),
        .take      (din_vld),
        .word_in   (din),
        .prev_word (prev_word)
    );

    bslip_splice #(
        .DATA_W   (DATA_W),
        .SLIP_MAX (SLIP_MAX),
        .IDX_W    (IDX_W)
    ) u_splice (
        .prev_word (prev_word),
        .cur_word  (din),
        .slip_eff  (slip_eff),
        .spliced   (spliced)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= din_vld;
            if (din_vld) dat_q <= spliced;
        end
    end

    assign dout_vld = vld_q;
    assign dout     = dat_q;

    // R1: one-cycle valid latency
    a_r1_vld_follow: assert property (@(posedge clk) disable iff (rst)
        din_vld |=> dout_vld);
    a_r1_vld_idle: assert property (@(posedge clk) disable iff (rst)
        !din_vld |=> !dout_vld);

    // R2: zero slip passes the word through
    a_r2_zero_pass: assert property (@(posedge clk) disable iff (rst)
        (din_vld && slip == '0) |=> dout == $past(din));

    // R8: output data held while idle
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !din_vld |=> $stable(dout));

endmodule

// File: tb/sim_tx_word_slipper.sv
`timescale 1ns/1ps
module sim_tx_word_slipper;

    localparam int W  = 64;
    localparam int SW = 5;
    localparam int WS = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vld = 1'b0;
    logic [W-1:0] din = '0;
    logic [SW-1:0] slip = '0;
    logic dvld;
    logic [W-1:0] dout;

    logic vld_s = 1'b0;
    logic [WS-1:0] din_s = '0;
    logic [SW-1:0] slip_s = '0;
    logic dvld_s;
    logic [WS-1:0] dout_s;

    int checks = 0;
    int errors = 0;
    logic [W-1:0]  hist   = '0;
    logic [WS-1:0] hist_s = '0;

    always #2 clk = ~clk;

    tx_word_slipper #(.DATA_W(W), .SLIP_W(SW)) u0 (
        .clk(clk), .rst(rst), .din_vld(vld), .din(din), .slip(slip),
        .dout_vld(dvld), .dout(dout));

    tx_word_slipper #(.DATA_W(WS), .SLIP_W(SW)) u1 (
        .clk(clk), .rst(rst), .din_vld(vld_s), .din(din_s), .slip(slip_s),
        .dout_vld(dvld_s), .dout(dout_s));

    function automatic logic [W-1:0] model(input logic [W-1:0] p,
                                           input logic [W-1:0] c, input int s);
        if (s == 0) return c;
        return (c << s) | (p >> (W - s));
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [W-1:0] d, input int s, input string req);
        logic [W-1:0] e;
        vld = 1'b1; din = d; slip = SW'(s);
        e = model(hist, d, (s > 31) ? 31 : s);
        @(negedge clk);
        vld = 1'b0;
        check({req, " valid"}, W'(dvld), W'(1));
        check(req, dout, e);
        hist = d;
    endtask

    task automatic idle(input int n, input string req);
        logic [W-1:0] held;
        held = dout;
        vld = 1'b0;
        for (int i = 0; i < n; i++) begin
            din = {$urandom, $urandom};
            slip = SW'($urandom);
            @(negedge clk);
            check({req, " valid low"}, W'(dvld), W'(0));
            check({req, " data held"}, dout, held);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R5 reset valid", W'(dvld), W'(0));
        check("R5 reset data", dout, '0);
        rst = 1'b0;
        hist = '0;
        hist_s = '0;
    endtask

    task automatic t_first_word;
        send(64'hFFFF_FFFF_FFFF_FFFF, 7, "R5 first word zero fill");
    endtask

    task automatic t_zero;
        send(64'h0123_4567_89AB_CDEF, 0, "R2 zero slip");
        send(64'hDEAD_BEEF_CAFE_F00D, 0, "R2 zero slip b");
    endtask

    task automatic t_slips;
        send(64'h8000_0000_0000_0001, 1, "R3 slip 1");
        send(64'h7FFF_FFFF_FFFF_FFFE, 1, "R3 slip 1 b");
        send(64'hA5A5_A5A5_5A5A_5A5A, 13, "R3 slip 13");
        send(64'hFEDC_BA98_7654_3210, 31, "R3 slip 31");
        send(64'h1111_2222_3333_4444, 31, "R3 slip 31 b");
    endtask

    task automatic t_change;
        send(64'h0F0F_0F0F_0F0F_0F0F, 4, "R7 slip 4");
        send(64'hF0F0_F0F0_F0F0_F0F0, 20, "R7 change to 20");
        send(64'h1234_5678_9ABC_DEF0, 0, "R7 change to 0");
        send(64'hCCCC_3333_CCCC_3333, 9, "R7 change to 9");
    endtask

    task automatic t_gap;
        send(64'hABCD_0000_0000_1234, 16, "R4 before gap");
        idle(3, "R8 R1 gap");
        send(64'h0000_FFFF_0000_FFFF, 16, "R4 after gap");
    endtask

    task automatic t_clamp;
        logic [WS-1:0] e;
        vld_s = 1'b1; din_s = 16'h8001; slip_s = SW'(3);
        @(negedge clk);
        e = (din_s << 3) | (hist_s >> 13);
        check("R6 small width slip 3", W'(dout_s), W'(e));
        hist_s = din_s;
        din_s = 16'h4321; slip_s = SW'(20);
        @(negedge clk);
        e = (din_s << 15) | (hist_s >> 1);
        check("R6 clamp 20 to 15", W'(dout_s), W'(e));
        hist_s = din_s;
        vld_s = 1'b0;
        @(negedge clk);
        check("R1 small width valid low", W'(dvld_s), W'(0));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_first_word;
        t_zero;
        t_slips;
        t_change;
        t_gap;
        t_clamp;
        t_reset;
        send(64'hFFFF_FFFF_FFFF_FFFF, 31, "R5 zero fill after reset");
        idle(1, "R8 tail");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule